// File: doc/BRIEF.md
# Square-Table Two-Operand Multiplier

This block multiplies two unsigned N-bit operands without an array of partial products. It first takes the midpoint of the two operands and how far each operand lies from it. It then reads the squares of the midpoint and the offset from one table through two read ports, and takes their difference. If the operands differ by an even amount, the midpoint is a whole number and the product is the difference of the two squares. If they differ by an odd amount, the true midpoint ends in one half. In that case each square is replaced by n·(n+1), which is formed as the table entry n² plus n itself, so no multiplier is used anywhere.

The table has 2^N entries of 2N bits. It is filled with i² when the design is elaborated and has synchronous read ports, so block RAM can hold it. The datapath is a two-stage pipeline. It accepts one operand pair per clock when `valid_in` is high and presents the matching product with `valid_out` two clocks later.

Top module: `sq_multiplier`

## Requirements
- R1: While `rst` is high at a rising clock edge, `valid_out` is cleared; it stays 0 after reset until a pair is accepted, even if `valid_in` was high during reset.
- R2: `valid_out` is high exactly in the cycle two rising edges after an edge that sampled `valid_in` high, and low otherwise.
- R3: Whenever `valid_out` is high, `product` equals the full 2N-bit unsigned product of the `a_in` and `b_in` sampled with the matching `valid_in`, for every operand pair.
- R4: When a_in + b_in is even (bit 0 of the sum is 0), with m = (a_in+b_in)>>1 and d = m − min(a_in,b_in), the product is m² − d².
- R5: When a_in + b_in is odd (bit 0 of the sum is 1), the product is m·(m+1) − d·(d+1) with m and d defined as in R4, each n·(n+1) being formed as n² + n.
- R6: When a_in equals b_in, the offset is 0 and the product is the square of the operand.
- R7: When either operand is 0, the product is 0.
- R8: Pairs presented on consecutive cycles produce one result per cycle, in the order they were accepted, with no bubble.
- R9: The largest operands give the correct results: (2^N−1)·(2^N−1), (2^N−1)·(2^N−2) and (2^N−1)·1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operand pair on a_in/b_in is to be multiplied |
| a_in | input | N | First unsigned operand |
| b_in | input | N | Second unsigned operand |
| valid_out | output | 1 | product holds a result this cycle |
| product | output | 2N | Unsigned product of the accepted pair |

## Verification
The assertions assume that `a_in` and `b_in` hold known values on every edge where `valid_in` is high. They also assume that reset is applied at the start, so the pipeline's valid bits start from a known state. The bench drives every input on the falling edge and holds operands at zero whenever no pair is presented. It streams all 2^(2N) operand pairs back to back, so the midpoint, offset and no-underflow checks inside the pipeline see every reachable value.

// File: rtl/sqm_pkg.sv
package sqm_pkg;
  // Width of a product or table entry for an n-bit operand.
  function automatic int unsigned prod_width(input int unsigned n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/sqm_prep.sv
module sqm_prep #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic         v1_q,
  output logic [N-1:0] avg_q,
  output logic [N-1:0] dev_q,
  output logic         odd_q
);
  localparam int unsigned SW = N + 1;

  logic [SW-1:0] sum;
  logic [N-1:0]  lo;
  logic [N-1:0]  avg;

  always_comb begin
    sum = {1'b0, a_in} + {1'b0, b_in};
    lo  = (a_in < b_in) ? a_in : b_in;
    avg = sum[SW-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst) v1_q <= 1'b0;
    else     v1_q <= valid_in;
    avg_q <= avg;
    dev_q <= avg - lo;
    odd_q <= sum[0];
  end

  // midpoint + offset (+1 when the sum is odd) recovers the larger operand
  logic [SW-1:0] recon;
  logic [N-1:0]  hi_in;
  assign recon = {1'b0, avg_q} + {1'b0, dev_q} + {{N{1'b0}}, odd_q};
  assign hi_in = (a_in > b_in) ? a_in : b_in;

  // R4
  prep_recon_chk: assert property (@(posedge clk) disable iff (rst)
    v1_q |-> recon == {1'b0, $past(hi_in)});
  // R6
  prep_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (v1_q && $past(a_in) == $past(b_in)) |-> (dev_q == '0 && !odd_q));
endmodule

// File: rtl/sqm_table.sv
module sqm_table #(
  parameter int unsigned N = 8
) (
  input  logic                                 clk,
  input  logic [N-1:0]                         addr_a,
  input  logic [N-1:0]                         addr_b,
  output logic [sqm_pkg::prod_width(N)-1:0]    q_a,
  output logic [sqm_pkg::prod_width(N)-1:0]    q_b
);
  localparam int unsigned TW    = sqm_pkg::prod_width(N);
  localparam int unsigned DEPTH = 1 << N;

  logic [TW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = TW'(i) * TW'(i);
    end
  end

  always_ff @(posedge clk) begin
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
  end
endmodule

// File: rtl/sqm_combine.sv
module sqm_combine #(
  parameter int unsigned N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 v1,
  input  logic [N-1:0]                         avg1,
  input  logic [N-1:0]                         dev1,
  input  logic                                 odd1,
  input  logic [sqm_pkg::prod_width(N)-1:0]    sq_avg,
  input  logic [sqm_pkg::prod_width(N)-1:0]    sq_dev,
  output logic                                 v2_q,
  output logic [sqm_pkg::prod_width(N)-1:0]    product
);
  localparam int unsigned TW = sqm_pkg::prod_width(N);

  logic [N-1:0]  avg2_q;
  logic [N-1:0]  dev2_q;
  logic          odd2_q;
  logic [TW-1:0] term_avg;
  logic [TW-1:0] term_dev;

  always_ff @(posedge clk) begin
    if (rst) v2_q <= 1'b0;
    else     v2_q <= v1;
    avg2_q <= avg1;
    dev2_q <= dev1;
    odd2_q <= odd1;
  end

  // n*(n+1) = n^2 + n for the odd case; plain squares for the even case
  always_comb begin
    term_avg = sq_avg + (odd2_q ? {{N{1'b0}}, avg2_q} : '0);
    term_dev = sq_dev + (odd2_q ? {{N{1'b0}}, dev2_q} : '0);
    product  = term_avg - term_dev;
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    v2_q |-> term_avg >= term_dev);
  // R5
  odd_offset_chk: assert property (@(posedge clk) disable iff (rst)
    v2_q |-> dev2_q <= avg2_q);
endmodule

// File: rtl/sq_multiplier.sv
module sq_multiplier #(
  parameter int unsigned N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 valid_in,
  input  logic [N-1:0]                         a_in,
  input  logic [N-1:0]                         b_in,
  output logic                                 valid_out,
  output logic [sqm_pkg::prod_width(N)-1:0]    product
);
  localparam int unsigned TW = sqm_pkg::prod_width(N);

  logic          v1;
  logic [N-1:0]  avg1;
  logic [N-1:0]  dev1;
  logic          odd1;
  logic [TW-1:0] sq_avg;
  logic [TW-1:0] sq_dev;

  sqm_prep #(.N(N)) u_prep (
    .clk(clk), .rst(rst), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
    .v1_q(v1), .avg_q(avg1), .dev_q(dev1), .odd_q(odd1)
  );

  sqm_table #(.N(N)) u_table (
    .clk(clk), .addr_a(avg1), .addr_b(dev1), .q_a(sq_avg), .q_b(sq_dev)
  );

  sqm_combine #(.N(N)) u_comb (
    .clk(clk), .rst(rst), .v1(v1), .avg1(avg1), .dev1(dev1), .odd1(odd1),
    .sq_avg(sq_avg), .sq_dev(sq_dev), .v2_q(valid_out), .product(product)
  );

  // cycles since reset, saturating, so checks never look before reset
  logic [1:0]    age_q;
  logic [TW-1:0] a_ext;
  logic [TW-1:0] b_ext;
  assign a_ext = {{N{1'b0}}, a_in};
  assign b_ext = {{N{1'b0}}, b_in};

  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> valid_out == $past(valid_in, 2));
  // R3
  product_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && valid_out) |-> product == $past(a_ext, 2) * $past(b_ext, 2));
  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && valid_out && ($past(a_in, 2) == '0 || $past(b_in, 2) == '0))
      |-> product == '0);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !valid_out);
endmodule

// File: tb/test_sq_multiplier.sv
module test_sq_multiplier;
  localparam int unsigned N  = 8;
  localparam int unsigned TW = 2 * N;
  localparam int unsigned MX = (1 << N) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_in = 1'b0;
  logic [N-1:0]  a_in = '0;
  logic [N-1:0]  b_in = '0;
  logic          valid_out;
  logic [TW-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;

  // expected pipeline: index 1 = driven one falling edge ago, 2 = two ago
  logic          hv1 = 1'b0, hv2 = 1'b0;
  logic [TW-1:0] he1 = '0,   he2 = '0;
  string         ht1 = "",   ht2 = "";

  always #2 clk = ~clk;

  sq_multiplier #(.N(N)) i_sq_multiplier (
    .clk(clk), .rst(rst), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
    .valid_out(valid_out), .product(product)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s valid_out actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_prod(input string tag, input logic [TW-1:0] act,
                            input logic [TW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s product actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one falling-edge step: check the output due now, then drive the next pair
  task automatic step(input logic v, input logic [N-1:0] a, input logic [N-1:0] b,
                      input string tag);
    @(negedge clk);
    check_bit({ht2, " R2"}, valid_out, hv2);
    if (hv2) check_prod(ht2, product, he2);
    hv2 = hv1; he2 = he1; ht2 = ht1;
    hv1 = v;   he1 = TW'(a) * TW'(b); ht1 = tag;
    valid_in = v;
    a_in = v ? a : '0;
    b_in = v ? b : '0;
  endtask

  task automatic drain();
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");
    step(1'b0, '0, '0, "idle");
  endtask

  task automatic t_reset();
    rst = 1'b1; valid_in = 1'b1; a_in = 8'd3; b_in = 8'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1 during reset", valid_out, 1'b0);
    rst = 1'b0; valid_in = 1'b0; a_in = '0; b_in = '0;
    hv1 = 0; hv2 = 0;
    @(negedge clk);
    check_bit("R1 after reset", valid_out, 1'b0);
    @(negedge clk);
    check_bit("R1 after reset+1", valid_out, 1'b0);
  endtask

  task automatic t_latency();
    step(1'b1, 8'd6, 8'd7, "R2 single");
    step(1'b0, '0, '0, "R2 gap");
    step(1'b0, '0, '0, "R2 gap");
    step(1'b1, 8'd9, 8'd2, "R2 single");
    drain();
  endtask

  task automatic t_even();
    step(1'b1, 8'd10, 8'd4,   "R4 even");
    step(1'b1, 8'd200, 8'd100, "R4 even");
    step(1'b1, 8'd1, 8'd255,  "R4 even");
    step(1'b1, 8'd128, 8'd2,  "R4 even");
    drain();
  endtask

  task automatic t_odd();
    step(1'b1, 8'd3, 8'd4,     "R5 odd");
    step(1'b1, 8'd255, 8'd128, "R5 odd");
    step(1'b1, 8'd17, 8'd200,  "R5 odd");
    step(1'b1, 8'd1, 8'd2,     "R5 odd");
    drain();
  endtask

  task automatic t_equal();
    step(1'b1, 8'd13, 8'd13,   "R6 equal");
    step(1'b1, 8'd255, 8'd255, "R6 equal");
    step(1'b1, 8'd1, 8'd1,     "R6 equal");
    drain();
  endtask

  task automatic t_zero();
    step(1'b1, 8'd0, 8'd0,   "R7 zero");
    step(1'b1, 8'd0, 8'd255, "R7 zero");
    step(1'b1, 8'd77, 8'd0,  "R7 zero");
    drain();
  endtask

  task automatic t_extreme();
    step(1'b1, MX[N-1:0], MX[N-1:0],       "R9 max*max");
    step(1'b1, MX[N-1:0], N'(MX - 1),      "R9 max*max-1");
    step(1'b1, MX[N-1:0], 8'd1,            "R9 max*1");
    drain();
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a <= MX; a++) begin
      for (int b = 0; b <= MX; b++) begin
        step(1'b1, N'(a), N'(b), "R3/R8 stream");
      end
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_even();
    t_odd();
    t_equal();
    t_zero();
    t_extreme();
    t_exhaustive();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule